// File: doc/BRIEF.md
# Programmable Video Timing Pattern Generator

This block produces a complete raster video stream from a single pixel clock: a vertical sync, a horizontal sync, a data-enable strobe and a 24-bit pixel word. No resolution is built in. Each of the three strobes is shaped by its own programmable tuple of an initial delay, a high time, a low time and a repeat count, all measured in pixel clocks. A full frame therefore follows from a handful of counter limits written through a simple write port.

While the data enable is high, the pixel carries one of two test fills. The first is a two-colour checkerboard whose run lengths and line-to-line colour swap are programmable. The second is a horizontal ramp that is the same on all three colour bytes. The block is meant for bring-up of a display or capture path without a real video source.

All settings go first into a live register set. A shadow copy takes them over only on a frame boundary, so a frame always uses one consistent setting. While the block is idle, the shadow copy follows the live registers on every clock.

Top module: `vtpg_top`

## Requirements
- R1: The mode field takes 0 for idle, 1 for checkerboard and 2 for ramp; 3 also means idle. While the active mode is idle, vsync, hsync and de are low and pixel is zero.
- R2: A frame lasts VD + max(VH,1) + max(VL,1) clocks, where VD is the vsync delay, VH its high time and VL its low time. Counted from frame time 0, vsync is low for VD clocks, high for max(VH,1) clocks, then low until the frame ends. The next frame follows at once.
- R3: hsync stays low for its delay. It then gives max(count,1) pulses, each high for max(high,1) clocks and low for max(low,1) clocks, and stays low for the rest of the frame.
- R4: de follows the same delay, high, low and repeat rule with its own tuple. Active line j and pixel i are counted from the de delay, with a period of high plus low.
- R5: pixel is zero whenever de is low.
- R6: In checkerboard mode the pixel holds colour A for max(repA,1) pixels, then colour B for max(repB,1) pixels, and so on. A run starts with the line's first colour. Colour words appear on pixel unchanged, with blue in bits 23:16, green in 15:8 and red in 7:0.
- R7: The first colour of active line j is A when floor(j / max(alt,1)) is even, and B otherwise.
- R8: In ramp mode all three bytes of pixel equal (i × inc) mod 256, where i is the pixel index within the active line.
- R9: A write changes the output only from the first frame that starts after the write clock. While idle, a write applies on the next clock.
- R10: A high, low or repeat value of zero, whether for timing, run length or alternation, acts as one. A delay of zero means the waveform starts at frame time 0.
- R11: Write addresses are: 0 mode, 1–3 vsync delay/high/low, 4–7 hsync delay/high/low/count, 8–11 de delay/high/low/count, 12 colour A, 13 colour B, 14 repeat A, 15 repeat B, 16 alternation, 17 ramp increment. After reset every field is zero except the increment, which is 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| cfg_we | input | 1 | Write strobe for the live register set |
| cfg_addr | input | 5 | Register address of the write |
| cfg_wdata | input | 24 | Write data; narrower fields take the low bits |
| vsync | output | 1 | Vertical sync |
| hsync | output | 1 | Horizontal sync |
| de | output | 1 | Data enable |
| pixel | output | 24 | Pixel word, zero outside de |

## Verification
The assertions assume that reset is released away from the clock edge. They also assume that a write can land in any clock, including the last clock of a frame. The ramp checks assume that two de-high clocks in a row belong to the same line unless a frame boundary lies between them, which the one-clock minimum low time guarantees. The stimulus programs timing values of a few dozen clocks at most, so that many frames fit in a run, and it rewrites every register at random points inside running frames, mixing in zero fields and the idle codes.

// File: rtl/vtpg_pkg.sv
package vtpg_pkg;
  localparam int TW   = 24;          // timing counter width
  localparam int LW   = 16;          // repeat counter width
  localparam int BW   = 8;           // byte width of counts and ramp
  localparam int PW   = 3 * BW;      // pixel width
  localparam int AW   = 5;           // write address width
  localparam int NWAVE = 3;
  localparam int WV_VS = 0;
  localparam int WV_HS = 1;
  localparam int WV_DE = 2;

  localparam logic [1:0] MODE_IDLE  = 2'd0;
  localparam logic [1:0] MODE_CHECK = 2'd1;
  localparam logic [1:0] MODE_RAMP  = 2'd2;

  localparam logic [AW-1:0] A_MODE   = 5'd0;
  localparam logic [AW-1:0] A_VS_DLY = 5'd1;
  localparam logic [AW-1:0] A_VS_HI  = 5'd2;
  localparam logic [AW-1:0] A_VS_LO  = 5'd3;
  localparam logic [AW-1:0] A_HS_DLY = 5'd4;
  localparam logic [AW-1:0] A_HS_HI  = 5'd5;
  localparam logic [AW-1:0] A_HS_LO  = 5'd6;
  localparam logic [AW-1:0] A_HS_NUM = 5'd7;
  localparam logic [AW-1:0] A_DE_DLY = 5'd8;
  localparam logic [AW-1:0] A_DE_HI  = 5'd9;
  localparam logic [AW-1:0] A_DE_LO  = 5'd10;
  localparam logic [AW-1:0] A_DE_NUM = 5'd11;
  localparam logic [AW-1:0] A_COL_A  = 5'd12;
  localparam logic [AW-1:0] A_COL_B  = 5'd13;
  localparam logic [AW-1:0] A_REP_A  = 5'd14;
  localparam logic [AW-1:0] A_REP_B  = 5'd15;
  localparam logic [AW-1:0] A_ALT    = 5'd16;
  localparam logic [AW-1:0] A_INC    = 5'd17;

  localparam logic [BW-1:0] INC_RESET = 8'h10;

  typedef enum logic [1:0] {PH_DLY, PH_HI, PH_LO, PH_DONE} wave_ph_e;

  typedef struct packed {
    logic [1:0]    mode;
    logic [TW-1:0] vs_dly;
    logic [TW-1:0] vs_hi;
    logic [TW-1:0] vs_lo;
    logic [TW-1:0] hs_dly;
    logic [LW-1:0] hs_hi;
    logic [LW-1:0] hs_lo;
    logic [LW-1:0] hs_num;
    logic [TW-1:0] de_dly;
    logic [LW-1:0] de_hi;
    logic [LW-1:0] de_lo;
    logic [LW-1:0] de_num;
    logic [PW-1:0] col_a;
    logic [PW-1:0] col_b;
    logic [BW-1:0] rep_a;
    logic [BW-1:0] rep_b;
    logic [BW-1:0] alt;
    logic [BW-1:0] inc;
  } cfg_t;

  function automatic cfg_t cfg_reset();
    cfg_t c;
    c     = '0;
    c.inc = INC_RESET;
    return c;
  endfunction
endpackage

// File: rtl/vtpg_regs.sv
module vtpg_regs
  import vtpg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [TW-1:0] wdata,
  input  logic          restart,
  output cfg_t          cfg_use,
  output logic [1:0]    sh_mode,
  output logic [PW-1:0] sh_col_a,
  output logic [PW-1:0] sh_col_b,
  output logic [BW-1:0] sh_inc,
  output logic          running
);
  cfg_t live_q, live_d;
  cfg_t sh_q, sh_d;

  always_comb begin
    live_d = live_q;
    if (we) begin
      case (addr)
        A_MODE:   live_d.mode   = wdata[1:0];
        A_VS_DLY: live_d.vs_dly = wdata;
        A_VS_HI:  live_d.vs_hi  = wdata;
        A_VS_LO:  live_d.vs_lo  = wdata;
        A_HS_DLY: live_d.hs_dly = wdata;
        A_HS_HI:  live_d.hs_hi  = wdata[LW-1:0];
        A_HS_LO:  live_d.hs_lo  = wdata[LW-1:0];
        A_HS_NUM: live_d.hs_num = wdata[LW-1:0];
        A_DE_DLY: live_d.de_dly = wdata;
        A_DE_HI:  live_d.de_hi  = wdata[LW-1:0];
        A_DE_LO:  live_d.de_lo  = wdata[LW-1:0];
        A_DE_NUM: live_d.de_num = wdata[LW-1:0];
        A_COL_A:  live_d.col_a  = wdata[PW-1:0];
        A_COL_B:  live_d.col_b  = wdata[PW-1:0];
        A_REP_A:  live_d.rep_a  = wdata[BW-1:0];
        A_REP_B:  live_d.rep_b  = wdata[BW-1:0];
        A_ALT:    live_d.alt    = wdata[BW-1:0];
        A_INC:    live_d.inc    = wdata[BW-1:0];
        default:  live_d = live_q;
      endcase
    end
    sh_d = restart ? live_q : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= cfg_reset();
      sh_q   <= cfg_reset();
    end else begin
      live_q <= live_d;
      sh_q   <= sh_d;
    end
  end

  // Values used to launch a frame come from the live set at the boundary.
  assign cfg_use  = restart ? live_q : sh_q;
  assign sh_mode  = sh_q.mode;
  assign sh_col_a = sh_q.col_a;
  assign sh_col_b = sh_q.col_b;
  assign sh_inc   = sh_q.inc;
  assign running  = (sh_q.mode == MODE_CHECK) || (sh_q.mode == MODE_RAMP);
endmodule

// File: rtl/vtpg_wave.sv
module vtpg_wave
  import vtpg_pkg::*;
#(
  parameter int W  = 24,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [W-1:0]  dly,
  input  logic [W-1:0]  hi,
  input  logic [W-1:0]  lo,
  input  logic [NW-1:0] num,
  output logic          level,
  output logic          last_hi,
  output logic          last_all
);
  localparam logic [W-1:0]  ONE_W = W'(1);
  localparam logic [NW-1:0] ONE_N = NW'(1);

  wave_ph_e      ph_q, ph_d;
  logic [W-1:0]  cnt_q, cnt_d;
  logic [NW-1:0] lines_q, lines_d;
  logic [W-1:0]  hi_e, lo_e;
  logic [NW-1:0] num_e;
  logic          cnt_end;

  assign hi_e    = (hi == '0)  ? ONE_W : hi;
  assign lo_e    = (lo == '0)  ? ONE_W : lo;
  assign num_e   = (num == '0) ? ONE_N : num;
  assign cnt_end = (cnt_q == ONE_W);

  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    lines_d = lines_q;
    if (restart) begin
      lines_d = num_e;
      if (dly == '0) begin
        ph_d  = PH_HI;
        cnt_d = hi_e;
      end else begin
        ph_d  = PH_DLY;
        cnt_d = dly;
      end
    end else begin
      case (ph_q)
        PH_DLY: begin
          if (cnt_end) begin
            ph_d  = PH_HI;
            cnt_d = hi_e;
          end else begin
            cnt_d = cnt_q - ONE_W;
          end
        end
        PH_HI: begin
          if (cnt_end) begin
            ph_d  = PH_LO;
            cnt_d = lo_e;
          end else begin
            cnt_d = cnt_q - ONE_W;
          end
        end
        PH_LO: begin
          if (cnt_end) begin
            if (lines_q <= ONE_N) begin
              ph_d = PH_DONE;
            end else begin
              ph_d    = PH_HI;
              cnt_d   = hi_e;
              lines_d = lines_q - ONE_N;
            end
          end else begin
            cnt_d = cnt_q - ONE_W;
          end
        end
        default: ph_d = PH_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_DONE;
      cnt_q   <= ONE_W;
      lines_q <= ONE_N;
    end else begin
      ph_q    <= ph_d;
      cnt_q   <= cnt_d;
      lines_q <= lines_d;
    end
  end

  assign level    = (ph_q == PH_HI);
  assign last_hi  = (ph_q == PH_HI) && cnt_end;
  assign last_all = (ph_q == PH_LO) && cnt_end && (lines_q <= ONE_N);
endmodule

// File: rtl/vtpg_pattern.sv
module vtpg_pattern
  import vtpg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          running,
  input  logic          de_raw,
  input  logic          line_end,
  input  logic [1:0]    mode,
  input  logic [PW-1:0] col_a,
  input  logic [PW-1:0] col_b,
  input  logic [BW-1:0] rep_a,
  input  logic [BW-1:0] rep_b,
  input  logic [BW-1:0] alt,
  input  logic [BW-1:0] inc,
  output logic [PW-1:0] pixel
);
  localparam logic [BW-1:0] ONE_B = BW'(1);

  logic          sel_q, sel_d;      // 0: colour A, 1: colour B
  logic          lsel_q, lsel_d;    // first colour of the current line
  logic [BW-1:0] run_q, run_d;
  logic [BW-1:0] alt_q, alt_d;
  logic [BW-1:0] ramp_q, ramp_d;
  logic [BW-1:0] rep_a_e, rep_b_e, alt_e;

  assign rep_a_e = (rep_a == '0) ? ONE_B : rep_a;
  assign rep_b_e = (rep_b == '0) ? ONE_B : rep_b;
  assign alt_e   = (alt == '0)   ? ONE_B : alt;

  always_comb begin
    sel_d  = sel_q;
    lsel_d = lsel_q;
    run_d  = run_q;
    alt_d  = alt_q;
    ramp_d = ramp_q;
    if (restart) begin
      sel_d  = 1'b0;
      lsel_d = 1'b0;
      run_d  = rep_a_e;
      alt_d  = alt_e;
      ramp_d = '0;
    end else begin
      if (line_end) begin
        if (alt_q <= ONE_B) begin
          lsel_d = ~lsel_q;
          alt_d  = alt_e;
        end else begin
          alt_d = alt_q - ONE_B;
        end
      end
      if (!de_raw) begin
        // blanking: prepare the first pixel of the coming line
        sel_d  = lsel_q;
        run_d  = lsel_q ? rep_b_e : rep_a_e;
        ramp_d = '0;
      end else begin
        ramp_d = ramp_q + inc;
        if (run_q <= ONE_B) begin
          sel_d = ~sel_q;
          run_d = sel_q ? rep_a_e : rep_b_e;
        end else begin
          run_d = run_q - ONE_B;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      lsel_q <= 1'b0;
      run_q  <= ONE_B;
      alt_q  <= ONE_B;
      ramp_q <= '0;
    end else begin
      sel_q  <= sel_d;
      lsel_q <= lsel_d;
      run_q  <= run_d;
      alt_q  <= alt_d;
      ramp_q <= ramp_d;
    end
  end

  always_comb begin
    pixel = '0;
    if (running && de_raw) begin
      case (mode)
        MODE_CHECK: pixel = sel_q ? col_b : col_a;
        MODE_RAMP:  pixel = {3{ramp_q}};
        default:    pixel = '0;
      endcase
    end
  end
endmodule

// File: rtl/vtpg_top.sv
module vtpg_top
  import vtpg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [23:0]   cfg_wdata,
  output logic          vsync,
  output logic          hsync,
  output logic          de,
  output logic [23:0]   pixel
);
  cfg_t          cfg_use;
  logic [1:0]    sh_mode;
  logic [PW-1:0] sh_col_a, sh_col_b;
  logic [BW-1:0] sh_inc;
  logic          running;
  logic          restart;

  logic [NWAVE-1:0] lvl, lhi, lall;
  logic [TW-1:0]    w_dly [NWAVE];
  logic [TW-1:0]    w_hi  [NWAVE];
  logic [TW-1:0]    w_lo  [NWAVE];
  logic [LW-1:0]    w_num [NWAVE];

  vtpg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .restart  (restart),
    .cfg_use  (cfg_use),
    .sh_mode  (sh_mode),
    .sh_col_a (sh_col_a),
    .sh_col_b (sh_col_b),
    .sh_inc   (sh_inc),
    .running  (running)
  );

  always_comb begin
    w_dly[WV_VS] = cfg_use.vs_dly;
    w_hi[WV_VS]  = cfg_use.vs_hi;
    w_lo[WV_VS]  = cfg_use.vs_lo;
    w_num[WV_VS] = LW'(1);
    w_dly[WV_HS] = cfg_use.hs_dly;
    w_hi[WV_HS]  = TW'(cfg_use.hs_hi);
    w_lo[WV_HS]  = TW'(cfg_use.hs_lo);
    w_num[WV_HS] = cfg_use.hs_num;
    w_dly[WV_DE] = cfg_use.de_dly;
    w_hi[WV_DE]  = TW'(cfg_use.de_hi);
    w_lo[WV_DE]  = TW'(cfg_use.de_lo);
    w_num[WV_DE] = cfg_use.de_num;
  end

  for (genvar gi = 0; gi < NWAVE; gi++) begin : g_wave
    vtpg_wave #(.W(TW), .NW(LW)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .dly      (w_dly[gi]),
      .hi       (w_hi[gi]),
      .lo       (w_lo[gi]),
      .num      (w_num[gi]),
      .level    (lvl[gi]),
      .last_hi  (lhi[gi]),
      .last_all (lall[gi])
    );
  end

  // The vsync waveform's final clock closes the frame; idle restarts every clock.
  assign restart = lall[WV_VS] | ~running;

  vtpg_pattern u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .running  (running),
    .de_raw   (lvl[WV_DE]),
    .line_end (lhi[WV_DE]),
    .mode     (sh_mode),
    .col_a    (sh_col_a),
    .col_b    (sh_col_b),
    .rep_a    (cfg_use.rep_a),
    .rep_b    (cfg_use.rep_b),
    .alt      (cfg_use.alt),
    .inc      (cfg_use.inc),
    .pixel    (pixel)
  );

  assign vsync = running & lvl[WV_VS];
  assign hsync = running & lvl[WV_HS];
  assign de    = running & lvl[WV_DE];

  logic unused_sig;
  assign unused_sig = ^{lhi[WV_HS:WV_VS], lall[WV_DE:WV_HS],
                        cfg_use.mode, cfg_use.col_a, cfg_use.col_b};
endmodule

// File: rtl/vtpg_checker.sv
module vtpg_checker
  import vtpg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          restart,
  input logic          running,
  input logic          de,
  input logic [PW-1:0] pixel,
  input logic [1:0]    mode,
  input logic [BW-1:0] inc,
  input logic [PW-1:0] col_a,
  input logic [PW-1:0] col_b
);
  // R5: blanking carries a zero pixel
  a_r5_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pixel == '0));

  // R6: checkerboard pixels are always one of the two colours
  a_r6_two_colours: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_CHECK && de) |-> (pixel == col_a || pixel == col_b));

  // R8: ramp restarts at zero on a new line or frame
  a_r8_ramp_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_RAMP && de && (!$past(de) || $past(restart)))
      |-> (pixel == '0));

  // R8: ramp advances by the increment on each de clock within a line
  a_r8_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_RAMP && de && $past(de) && !$past(restart))
      |-> (pixel[BW-1:0] == BW'($past(pixel[BW-1:0]) + inc)));

  // R8: ramp bytes agree across the three channels
  a_r8_ramp_gray: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MODE_RAMP) |->
      (pixel[PW-1:2*BW] == pixel[BW-1:0] && pixel[2*BW-1:BW] == pixel[BW-1:0]));

  // R9: the active setting changes only at a frame boundary
  a_r9_hold_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> ($stable(mode) && $stable(inc) && $stable(col_a) && $stable(col_b)));
endmodule

bind vtpg_top vtpg_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .restart (restart),
  .running (running),
  .de      (de),
  .pixel   (pixel),
  .mode    (sh_mode),
  .inc     (sh_inc),
  .col_a   (sh_col_a),
  .col_b   (sh_col_b)
);

// File: tb/vtpg_top_tb_top.sv
module vtpg_top_tb_top;
  import vtpg_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [23:0] cfg_wdata;
  logic        vsync, hsync, de;
  logic [23:0] pixel;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  vtpg_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .vsync(vsync), .hsync(hsync), .de(de), .pixel(pixel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // ---------------- reference model ----------------
  cfg_t   m_live, m_sh;
  longint m_t;
  bit     m_run;

  function automatic longint e1(longint v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit wave(longint t, longint d, longint h, longint l, longint n);
    longint u, p;
    if (t < d) return 1'b0;
    u = t - d;
    p = e1(h) + e1(l);
    return ((u / p) < e1(n)) && ((u % p) < e1(h));
  endfunction

  function automatic longint frame_len(cfg_t c);
    return longint'(c.vs_dly) + e1(longint'(c.vs_hi)) + e1(longint'(c.vs_lo));
  endfunction

  function automatic cfg_t wr_field(cfg_t c, logic [4:0] a, logic [23:0] d);
    cfg_t r = c;
    case (a)
      A_MODE:   r.mode   = d[1:0];
      A_VS_DLY: r.vs_dly = d;
      A_VS_HI:  r.vs_hi  = d;
      A_VS_LO:  r.vs_lo  = d;
      A_HS_DLY: r.hs_dly = d;
      A_HS_HI:  r.hs_hi  = d[15:0];
      A_HS_LO:  r.hs_lo  = d[15:0];
      A_HS_NUM: r.hs_num = d[15:0];
      A_DE_DLY: r.de_dly = d;
      A_DE_HI:  r.de_hi  = d[15:0];
      A_DE_LO:  r.de_lo  = d[15:0];
      A_DE_NUM: r.de_num = d[15:0];
      A_COL_A:  r.col_a  = d;
      A_COL_B:  r.col_b  = d;
      A_REP_A:  r.rep_a  = d[7:0];
      A_REP_B:  r.rep_b  = d[7:0];
      A_ALT:    r.alt    = d[7:0];
      A_INC:    r.inc    = d[7:0];
      default:  r = c;
    endcase
    return r;
  endfunction

  // pixel for frame time t, assuming de is high there
  function automatic logic [23:0] pix_model(cfg_t c, longint t, output string tag);
    longint u, p, j, i, pos, r;
    bit sel;
    logic [7:0] v;
    u = t - longint'(c.de_dly);
    p = e1(longint'(c.de_hi)) + e1(longint'(c.de_lo));
    j = u / p;
    i = u % p;
    if (c.mode == MODE_CHECK) begin
      tag = (j >= e1(longint'(c.alt))) ? "R7" : "R6";
      sel = ((j / e1(longint'(c.alt))) % 2) == 1;
      pos = i;
      forever begin
        r = sel ? e1(longint'(c.rep_b)) : e1(longint'(c.rep_a));
        if (pos < r) break;
        pos -= r;
        sel = ~sel;
      end
      return sel ? c.col_b : c.col_a;
    end
    tag = "R8";
    v = 8'((i * longint'(c.inc)) & 255);
    return {v, v, v};
  endfunction

  task automatic model_edge(bit we, logic [4:0] a, logic [23:0] d);
    bit rs;
    rs = !m_run || (m_t == frame_len(m_sh) - 1);
    if (rs) begin
      m_sh  = m_live;
      m_t   = 0;
      m_run = (m_sh.mode == MODE_CHECK) || (m_sh.mode == MODE_RAMP);
    end else begin
      m_t++;
    end
    if (we) m_live = wr_field(m_live, a, d);
  endtask

  task automatic check_now();
    bit ev, eh, ed;
    logic [23:0] ep;
    string ptag;
    ev = 0; eh = 0; ed = 0; ep = '0; ptag = "R5";
    if (m_run) begin
      ev = wave(m_t, m_sh.vs_dly, m_sh.vs_hi, m_sh.vs_lo, 1);
      eh = wave(m_t, m_sh.hs_dly, m_sh.hs_hi, m_sh.hs_lo, m_sh.hs_num);
      ed = wave(m_t, m_sh.de_dly, m_sh.de_hi, m_sh.de_lo, m_sh.de_num);
      if (ed) ep = pix_model(m_sh, m_t, ptag);
    end else begin
      ptag = "R1";
    end
    n_chk++;
    if (vsync !== ev || hsync !== eh || de !== ed || pixel !== ep) begin
      n_bad++;
      if (vsync !== ev) $display("FAIL %s vsync t=%0d got %b exp %b", m_run ? "R2" : "R1", m_t, vsync, ev);
      if (hsync !== eh) $display("FAIL %s hsync t=%0d got %b exp %b", m_run ? "R3" : "R1", m_t, hsync, eh);
      if (de !== ed)    $display("FAIL %s de t=%0d got %b exp %b", m_run ? "R4" : "R1", m_t, de, ed);
      if (pixel !== ep) $display("FAIL %s pixel t=%0d got %h exp %h", ptag, m_t, pixel, ep);
    end
  endtask

  task automatic tick(bit we, logic [4:0] a, logic [23:0] d);
    cfg_we    = we;
    cfg_addr  = a;
    cfg_wdata = d;
    model_edge(we, a, d);
    @(negedge clk);
    check_now();
  endtask

  task automatic wr(logic [4:0] a, logic [23:0] d);
    tick(1'b1, a, d);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) tick(1'b0, '0, '0);
  endtask

  task automatic program_timing(int vd, int vh, int vl, int hd, int hh, int hl, int hn,
                                int dd, int dh, int dl, int dn);
    wr(A_VS_DLY, 24'(vd)); wr(A_VS_HI, 24'(vh)); wr(A_VS_LO, 24'(vl));
    wr(A_HS_DLY, 24'(hd)); wr(A_HS_HI, 24'(hh)); wr(A_HS_LO, 24'(hl)); wr(A_HS_NUM, 24'(hn));
    wr(A_DE_DLY, 24'(dd)); wr(A_DE_HI, 24'(dh)); wr(A_DE_LO, 24'(dl)); wr(A_DE_NUM, 24'(dn));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired after %0d checks", n_chk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    m_live = cfg_reset();
    m_sh   = cfg_reset();
    m_t    = 0;
    m_run  = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1, R11: reset state is idle with quiet outputs
    n_chk++;
    if (vsync !== 1'b0 || hsync !== 1'b0 || de !== 1'b0 || pixel !== '0) begin
      n_bad++;
      $display("FAIL R11 reset outputs got %b%b%b %h exp 000 000000", vsync, hsync, de, pixel);
    end
    rst_n = 1'b1;
    check_now();
    idle(5);

    // R2 R3 R4 R6 R7: directed checkerboard frame
    program_timing(3, 4, 60, 2, 2, 5, 6, 9, 10, 3, 5);
    wr(A_COL_A, 24'hfecc00); wr(A_COL_B, 24'h006aa7);
    wr(A_REP_A, 3); wr(A_REP_B, 2); wr(A_ALT, 2);
    wr(A_MODE, MODE_CHECK);
    idle(220);

    // R8 R11: ramp with the reset increment of 0x10, switched mid-frame (R9)
    idle(17);
    wr(A_MODE, MODE_RAMP);
    idle(200);
    wr(A_INC, 8'h07);
    idle(150);

    // R10: zero high, low and repeat values act as one; zero delays
    program_timing(0, 0, 30, 0, 0, 0, 0, 0, 0, 0, 0);
    wr(A_REP_A, 0); wr(A_REP_B, 0); wr(A_ALT, 0);
    wr(A_MODE, MODE_CHECK);
    idle(120);

    // R1: idle codes 0 and 3 quieten the outputs after the frame ends (R9)
    wr(A_MODE, 2'd3);
    idle(80);
    wr(A_MODE, MODE_RAMP);
    idle(60);
    wr(A_MODE, MODE_IDLE);
    idle(60);

    // random configurations rewritten inside running frames (R9)
    for (int it = 0; it < 45; it++) begin
      wr(A_VS_DLY, 24'($urandom_range(5, 0)));
      wr(A_VS_HI,  24'($urandom_range(4, 0)));
      wr(A_VS_LO,  24'($urandom_range(90, 25)));
      wr(A_HS_DLY, 24'($urandom_range(4, 0)));
      wr(A_HS_HI,  24'($urandom_range(3, 0)));
      wr(A_HS_LO,  24'($urandom_range(6, 0)));
      wr(A_HS_NUM, 24'($urandom_range(12, 0)));
      wr(A_DE_DLY, 24'($urandom_range(10, 0)));
      wr(A_DE_HI,  24'($urandom_range(12, 0)));
      wr(A_DE_LO,  24'($urandom_range(4, 0)));
      wr(A_DE_NUM, 24'($urandom_range(8, 0)));
      wr(A_COL_A,  24'($urandom));
      wr(A_COL_B,  24'($urandom));
      wr(A_REP_A,  24'($urandom_range(4, 0)));
      wr(A_REP_B,  24'($urandom_range(4, 0)));
      wr(A_ALT,    24'($urandom_range(3, 0)));
      wr(A_INC,    24'($urandom_range(255, 0)));
      wr(A_MODE,   24'($urandom_range(3, 0)));
      idle(int'($urandom_range(300, 150)));
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule